// File: doc/BRIEF.md
# Multi-Cycle Instruction Timing Sequencer

This block is the control sequencer of a small accumulator-style processor that runs one instruction at a time. A timing counter walks through seven slots, T0 to T6, and the block turns the current slot, the class of the instruction held in the instruction register and two feedback inputs into the control strobes for the datapath. The datapath (program counter, address register, data register, ALU, memory) lives outside. It follows these strobes and returns a memory-ready flag and an ALU condition flag.

Fetch uses T0 and T1. T2 decodes the opcode into one active decoder line. T3 depends on the instruction class. An indirect memory instruction fetches its effective address. A direct memory instruction idles for that slot. An instruction with the register/I-O opcode executes and finishes. Memory instructions then read the operand, run the ALU and write the result back in T4 to T6. A memory access holds its slot until memory reports ready. When the ALU condition is present in the last cycle of an instruction, the program counter is reloaded with a branch target instead of keeping its incremented value. The counter then returns to T0.

Top module: `instr_timing_seq`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. A clock edge with it low puts the counter in T0, whatever slot it was in. `t_slot` is one-hot, and bit i high means slot Ti.
- R2: In T0, `ld_mar` is high with `mar_src` = 0 (address taken from the program counter), and the next slot is always T1.
- R3: In T1, `mem_rd` is high. In the cycle where `mem_ready` is high, `ld_ir` and `inc_pc` pulse together and the counter moves to T2.
- R4: In T2 only, `dec_line` has exactly one bit set, at the index equal to `ir_opcode` (3 bits). In every other slot it is all zeros.
- R5: In T2, an instruction whose opcode is not 7 (a memory instruction) drives `ld_mar` with `mar_src` = 1 (address field of the instruction). Opcode 7 leaves `ld_mar` low.
- R6: In T3, a memory instruction with `ir_indirect` = 1 drives `mem_rd`. On `mem_ready` it pulses `ld_mar` with `mar_src` = 2 (data just read from memory) and moves to T4.
- R7: In T3, a memory instruction with `ir_indirect` = 0 drives no strobe and moves to T4 after one cycle.
- R8: In T3, opcode 7 (register/I-O class) pulses `alu_en` for one cycle and the instruction completes, so the next slot is T0. Without stalls such an instruction lasts 4 cycles.
- R9: A memory instruction reads its operand in T4 (`mem_rd`, then `ld_dr` on `mem_ready`). It runs the ALU in T5 (`alu_en`, one cycle). It holds `wr_back` in T6 until `mem_ready`, then completes. Without stalls it lasts 7 cycles.
- R10: `ld_pc` is high only in the completing cycle of an instruction, and only when `alu_cond` is high. `alu_cond` has no effect in any other cycle.
- R11: While `mem_rd` or `wr_back` is high and `mem_ready` is low, the slot does not change. Each stall cycle lengthens the instruction by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_opcode | input | 3 | Opcode field of the instruction register |
| ir_indirect | input | 1 | Indirect-address bit of the instruction register |
| mem_ready | input | 1 | Memory has completed the current access |
| alu_cond | input | 1 | ALU condition asking for a program-counter reload |
| t_slot | output | 7 | One-hot timing slot T0..T6 |
| dec_line | output | 8 | One-hot opcode decoder line, valid in T2 |
| mar_src | output | 2 | Address-register source: 0 PC, 1 address field, 2 memory data |
| ld_mar | output | 1 | Load the memory address register |
| mem_rd | output | 1 | Memory read request |
| ld_ir | output | 1 | Load the instruction register |
| inc_pc | output | 1 | Increment the program counter |
| ld_pc | output | 1 | Load the program counter with a branch target |
| ld_dr | output | 1 | Load the data register with the operand |
| alu_en | output | 1 | Run the ALU operation |
| wr_back | output | 1 | Write the result back to memory |

## Verification
The instruction loop covers the three classes: register/I-O, direct memory and indirect memory. Each class is run with and without the ALU condition and with memory wait times of zero to three cycles. The length of each instruction and the number of cycles of each strobe separate the three T3 behaviours and show stall handling at every access. Directed steps hold memory not-ready during fetch, check that T3 stays idle for a direct instruction, and apply reset in the middle of an instruction. Holding `alu_cond` high for the whole instruction checks that the PC is reloaded only in the final cycle.

// File: rtl/its_pkg.sv
package its_pkg;

   localparam int unsigned SLOT_COUNT = 7;

   localparam int unsigned S_T0 = 0;
   localparam int unsigned S_T1 = 1;
   localparam int unsigned S_T2 = 2;
   localparam int unsigned S_T3 = 3;
   localparam int unsigned S_T4 = 4;
   localparam int unsigned S_T5 = 5;
   localparam int unsigned S_T6 = 6;

   typedef enum logic [1:0] {
      MAR_FROM_PC   = 2'd0,
      MAR_FROM_ADDR = 2'd1,
      MAR_FROM_MEM  = 2'd2
   } mar_src_e;

   typedef struct packed {
      logic     ld_mar;
      logic     mem_rd;
      logic     ld_ir;
      logic     inc_pc;
      logic     ld_pc;
      logic     ld_dr;
      logic     alu_en;
      logic     wr_back;
      mar_src_e mar_src;
   } strobe_t;

endpackage

// File: rtl/its_slot_counter.sv
module its_slot_counter #(
   parameter int unsigned SLOTS   = 7,
   parameter bit          ONE_HOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             finish,
   output logic [SLOTS-1:0] slot_oh
);

   localparam int unsigned CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("its_slot_counter: SLOTS must be at least 2");
   end

   if (ONE_HOT) begin : g_onehot
      logic [SLOTS-1:0] state_q;

      always_ff @(posedge clk) begin
         if (!rst_n || finish) begin
            state_q <= {{(SLOTS-1){1'b0}}, 1'b1};
         end else if (advance) begin
            state_q <= {state_q[SLOTS-2:0], 1'b0};
         end
      end

      assign slot_oh = state_q;
   end else begin : g_binary
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || finish) begin
            cnt_q <= '0;
         end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      for (genvar i = 0; i < SLOTS; i++) begin : g_dec
         assign slot_oh[i] = (cnt_q == CNT_W'(i));
      end
   end

   // R1: a reset edge always lands the counter in T0
   p_reset_t0_r1: assert property (@(posedge clk) !rst_n |=> slot_oh[0]);

endmodule

// File: rtl/its_op_decoder.sv
module its_op_decoder #(
   parameter int unsigned OPC_W      = 3,
   parameter int unsigned REG_OPCODE = 7
) (
   input  logic                  enable,
   input  logic [OPC_W-1:0]      opcode,
   output logic [(1<<OPC_W)-1:0] line,
   output logic                  is_reg_class
);

   localparam int unsigned LINES = 1 << OPC_W;

   if (REG_OPCODE >= LINES) begin : g_bad_reg_op
      $error("its_op_decoder: REG_OPCODE does not fit in OPC_W bits");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign line[i] = enable && (opcode == OPC_W'(i));
   end

   assign is_reg_class = (opcode == OPC_W'(REG_OPCODE));

endmodule

// File: rtl/its_ctrl_gen.sv
module its_ctrl_gen
   import its_pkg::*;
#(
   parameter int unsigned SLOTS = 7
) (
   input  logic [SLOTS-1:0] slot_oh,
   input  logic             is_reg_class,
   input  logic             indirect,
   input  logic             mem_ready,
   input  logic             alu_cond,
   output strobe_t          strb,
   output logic             advance,
   output logic             finish
);

   if (SLOTS != SLOT_COUNT) begin : g_bad_slots
      $error("its_ctrl_gen: sequence needs exactly SLOT_COUNT slots");
   end

   logic mem_class;
   logic ind_mem;

   assign mem_class = !is_reg_class;
   assign ind_mem   = mem_class && indirect;

   always_comb begin
      strb         = '0;
      strb.mar_src = MAR_FROM_PC;
      advance      = 1'b0;
      finish       = 1'b0;

      if (slot_oh[S_T0]) begin
         strb.ld_mar  = 1'b1;
         strb.mar_src = MAR_FROM_PC;
         advance      = 1'b1;
      end

      if (slot_oh[S_T1]) begin
         strb.mem_rd = 1'b1;
         strb.ld_ir  = mem_ready;
         strb.inc_pc = mem_ready;
         advance     = mem_ready;
      end

      if (slot_oh[S_T2]) begin
         if (mem_class) begin
            strb.ld_mar  = 1'b1;
            strb.mar_src = MAR_FROM_ADDR;
         end
         advance = 1'b1;
      end

      if (slot_oh[S_T3]) begin
         if (is_reg_class) begin
            strb.alu_en = 1'b1;
            finish      = 1'b1;
         end else if (ind_mem) begin
            strb.mem_rd  = 1'b1;
            strb.ld_mar  = mem_ready;
            strb.mar_src = mem_ready ? MAR_FROM_MEM : MAR_FROM_PC;
            advance      = mem_ready;
         end else begin
            advance = 1'b1;
         end
      end

      if (slot_oh[S_T4]) begin
         strb.mem_rd = 1'b1;
         strb.ld_dr  = mem_ready;
         advance     = mem_ready;
      end

      if (slot_oh[S_T5]) begin
         strb.alu_en = 1'b1;
         advance     = 1'b1;
      end

      if (slot_oh[S_T6]) begin
         strb.wr_back = 1'b1;
         finish       = mem_ready;
      end

      strb.ld_pc = finish && alu_cond;
   end

endmodule

// File: rtl/instr_timing_seq.sv
module instr_timing_seq
   import its_pkg::*;
#(
   parameter int unsigned OPC_W      = 3,
   parameter int unsigned REG_OPCODE = 7,
   parameter bit          ONE_HOT    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [OPC_W-1:0]      ir_opcode,
   input  logic                  ir_indirect,
   input  logic                  mem_ready,
   input  logic                  alu_cond,
   output logic [6:0]            t_slot,
   output logic [(1<<OPC_W)-1:0] dec_line,
   output logic [1:0]            mar_src,
   output logic                  ld_mar,
   output logic                  mem_rd,
   output logic                  ld_ir,
   output logic                  inc_pc,
   output logic                  ld_pc,
   output logic                  ld_dr,
   output logic                  alu_en,
   output logic                  wr_back
);

   localparam int unsigned SLOTS = SLOT_COUNT;

   if (OPC_W < 1 || OPC_W > 6) begin : g_bad_opc_w
      $error("instr_timing_seq: OPC_W out of range");
   end

   logic [SLOTS-1:0] slot_oh;
   logic             advance;
   logic             finish;
   logic             is_reg_class;
   strobe_t          strb;

   its_slot_counter #(
      .SLOTS   (SLOTS),
      .ONE_HOT (ONE_HOT)
   ) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .finish  (finish),
      .slot_oh (slot_oh)
   );

   its_op_decoder #(
      .OPC_W      (OPC_W),
      .REG_OPCODE (REG_OPCODE)
   ) dec_i (
      .enable       (slot_oh[S_T2]),
      .opcode       (ir_opcode),
      .line         (dec_line),
      .is_reg_class (is_reg_class)
   );

   its_ctrl_gen #(
      .SLOTS (SLOTS)
   ) ctl_i (
      .slot_oh      (slot_oh),
      .is_reg_class (is_reg_class),
      .indirect     (ir_indirect),
      .mem_ready    (mem_ready),
      .alu_cond     (alu_cond),
      .strb         (strb),
      .advance      (advance),
      .finish       (finish)
   );

   assign t_slot  = slot_oh;
   assign mar_src = strb.mar_src;
   assign ld_mar  = strb.ld_mar;
   assign mem_rd  = strb.mem_rd;
   assign ld_ir   = strb.ld_ir;
   assign inc_pc  = strb.inc_pc;
   assign ld_pc   = strb.ld_pc;
   assign ld_dr   = strb.ld_dr;
   assign alu_en  = strb.alu_en;
   assign wr_back = strb.wr_back;

   // R2: T0 never stalls
   p_fetch_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      t_slot[S_T0] |=> t_slot[S_T1]);

   // R3: loading IR ends the fetch
   p_ir_then_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |=> t_slot[S_T2]);

   // R4: the decoder shows one line during T2
   p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      t_slot[S_T2] |-> $onehot(dec_line));

   // R8: register class is done after T3
   p_reg_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (t_slot[S_T3] && ir_opcode == OPC_W'(REG_OPCODE)) |=> t_slot[S_T0]);

   // R10: a PC reload is followed by a fresh fetch
   p_ldpc_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_pc |=> t_slot[S_T0]);

   // R11: an unfinished memory access holds the slot
   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || wr_back) && !mem_ready) |=> $stable(t_slot));

endmodule

// File: tb/instr_timing_seq_tb_top.sv
`timescale 1ns/1ps
module instr_timing_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ir_opcode = 3'd0;
   logic       ir_indirect = 1'b0;
   logic       mem_ready = 1'b0;
   logic       alu_cond = 1'b0;
   logic [6:0] t_slot;
   logic [7:0] dec_line;
   logic [1:0] mar_src;
   logic       ld_mar, mem_rd, ld_ir, inc_pc, ld_pc, ld_dr, alu_en, wr_back;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   instr_timing_seq dut_i (
      .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_indirect(ir_indirect),
      .mem_ready(mem_ready), .alu_cond(alu_cond), .t_slot(t_slot),
      .dec_line(dec_line), .mar_src(mar_src), .ld_mar(ld_mar), .mem_rd(mem_rd),
      .ld_ir(ld_ir), .inc_pc(inc_pc), .ld_pc(ld_pc), .ld_dr(ld_dr),
      .alu_en(alu_en), .wr_back(wr_back)
   );

   // {opcode[2:0], indirect, alu_cond, wait[3:0]}
   localparam logic [8:0] VEC [8] = '{
      {3'd7, 1'b0, 1'b0, 4'd0},
      {3'd7, 1'b1, 1'b1, 4'd2},
      {3'd1, 1'b0, 1'b0, 4'd0},
      {3'd3, 1'b0, 1'b1, 4'd1},
      {3'd2, 1'b1, 1'b0, 4'd0},
      {3'd5, 1'b1, 1'b1, 4'd3},
      {3'd0, 1'b0, 1'b1, 4'd0},
      {3'd6, 1'b1, 1'b0, 4'd1}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic run_vec(input logic [2:0] opc, input logic ind, input logic cond,
                          input int dly);
      int cyc = 0, waitc = 0;
      int n_mar = 0, n_rd = 0, n_ir = 0, n_inc = 0, n_pc = 0, n_dr = 0;
      int n_alu = 0, n_wr = 0, n_dec = 0, t3_act = 0, pc_cyc = -1;
      int dec_val = 0, t2_src = -1, t3_src = -1;
      bit reg_c;
      int acc, exp_cyc;
      reg_c = (opc == 3'd7);
      ir_opcode = opc;
      ir_indirect = ind;
      alu_cond = cond;
      while (cyc < 200) begin
         if (mem_rd || wr_back) begin
            if (waitc == dly) begin mem_ready = 1'b1; waitc = 0; end
            else begin mem_ready = 1'b0; waitc++; end
         end else mem_ready = 1'b0;
         #1;
         if (cyc > 0 && t_slot[0]) break;
         n_mar += ld_mar; n_rd += mem_rd; n_ir += ld_ir; n_inc += inc_pc;
         n_dr += ld_dr; n_alu += alu_en; n_wr += wr_back;
         if (ld_pc) begin n_pc++; pc_cyc = cyc; end
         if (dec_line != 0) n_dec++;
         if (t_slot[2]) begin dec_val = dec_line; if (ld_mar) t2_src = mar_src; end
         if (t_slot[3]) begin
            t3_act += ld_mar + mem_rd + ld_dr + alu_en + wr_back + ld_pc + ld_ir + inc_pc;
            if (ld_mar) t3_src = mar_src;
         end
         cyc++;
         @(posedge clk);
         @(negedge clk);
         #1;
      end
      mem_ready = 1'b0;
      acc = reg_c ? 1 : (ind ? 4 : 3);
      exp_cyc = (reg_c ? 4 : 7) + dly * acc;
      chk("R8/R9/R11 instruction length", cyc, exp_cyc);
      chk("R3 ld_ir pulses", n_ir, 1);
      chk("R3 inc_pc pulses", n_inc, 1);
      chk("R4 decoder line", dec_val, 1 << opc);
      chk("R4 decoder active cycles", n_dec, 1);
      chk("R2/R5/R6 ld_mar pulses", n_mar, reg_c ? 1 : (ind ? 3 : 2));
      chk("R11 mem_rd cycles", n_rd, (reg_c ? 1 : (ind ? 3 : 2)) * (dly + 1));
      chk("R9 wr_back cycles", n_wr, reg_c ? 0 : dly + 1);
      chk("R9 ld_dr pulses", n_dr, reg_c ? 0 : 1);
      chk("R8/R9 alu_en cycles", n_alu, 1);
      chk("R10 ld_pc pulses", n_pc, cond);
      if (cond) chk("R10 ld_pc in final cycle", pc_cyc, cyc - 1);
      if (!reg_c) chk("R5 mar_src in T2", t2_src, 1);
      if (!reg_c && ind) chk("R6 mar_src in T3", t3_src, 2);
      if (!reg_c && !ind) chk("R7 direct T3 idle", t3_act, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick();
      tick();
      rst_n = 1'b1;
      #1;
      // R1 / R2: reset state
      chk("R1 reset slot", t_slot, 7'b0000001);
      chk("R2 ld_mar in T0", ld_mar, 1);
      chk("R2 mar_src in T0", mar_src, 0);
      chk("R1 idle strobes", mem_rd + ld_ir + inc_pc + ld_pc + ld_dr + alu_en + wr_back, 0);
      ir_opcode = 3'd1; ir_indirect = 1'b0; alu_cond = 1'b1;
      tick();
      chk("R2 T0 to T1", t_slot, 7'b0000010);
      chk("R3 mem_rd in T1", mem_rd, 1);
      // R11: fetch stall
      for (int k = 0; k < 5; k++) tick();
      chk("R11 T1 held", t_slot, 7'b0000010);
      chk("R11 no ld_ir while waiting", ld_ir, 0);
      mem_ready = 1'b1;
      #1;
      chk("R3 ld_ir with ready", ld_ir, 1);
      chk("R3 inc_pc with ready", inc_pc, 1);
      tick();
      mem_ready = 1'b0;
      #1;
      chk("R3 reached T2", t_slot, 7'b0000100);
      chk("R5 ld_mar in T2", ld_mar, 1);
      chk("R5 mar_src in T2", mar_src, 1);
      tick();
      chk("R7 direct T3 strobes", ld_mar + mem_rd + ld_dr + alu_en + wr_back + ld_pc, 0);
      chk("R10 alu_cond ignored mid-instruction", ld_pc, 0);
      tick();
      chk("R7 T3 to T4", t_slot, 7'b0010000);
      // R1: reset mid-instruction
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      alu_cond = 1'b0;
      #1;
      chk("R1 mid-run reset", t_slot, 7'b0000001);

      for (int v = 0; v < 8; v++) begin
         run_vec(VEC[v][8:6], VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule